// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller with Shortcut Mirrors

This block collects 72 level-sensitive interrupt sources into three groups: a basic group of 8 lines (group 0) and two wide groups of 32 lines each (groups 1 and 2). Each source is gated by its own enable bit. Software sets enable bits by writing ones to an enable register and clears them by writing ones to a disable register. It reads the gated state of each group from a pending register. A single interrupt line goes to the processor.

The pending word of group 0 is the entry point for software. Bits 0 to 7 hold the basic sources. Bits 8 and 9 summarise groups 1 and 2. Bits 10 to 20 mirror eleven selected sources of the wide groups, so a handler can identify a frequent source with one read. A mirrored source never raises its group's summary bit. The summary bits have no mask of their own. A mirrored source is gated only by its own group's enable bit.

The register port is a plain single-cycle port. A write takes effect on the clock edge at which `wr_en` is high. Read data is combinational from `addr`.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset all enable bits are zero, every pending register reads zero and `irq_o` is low.
- R2: A write to an enable register sets each enable bit whose data bit is 1 and leaves the bits written 0 unchanged. Reading an enable register returns the current mask. The enable offsets are 0x18 (group 0, bits 0-7), 0x10 (group 1) and 0x14 (group 2).
- R3: A write to a disable register clears each enable bit whose data bit is 1 and leaves the others unchanged. The disable offsets are 0x24 (group 0), 0x1C (group 1) and 0x20 (group 2).
- R4: The group 1 pending register at 0x04 and the group 2 pending register at 0x08 read as each live source level ANDed with its enable bit, including the mirrored sources.
- R5: Bits 0-7 of the group 0 pending register at 0x00 read as basic source level ANDed with the group 0 enable.
- R6: Bits 10-14 of 0x00 mirror the gated group 1 sources 7, 9, 10, 18 and 19, in that order. Bits 15-20 mirror the gated group 2 sources 21, 22, 23, 24, 25 and 30, in that order.
- R7: Bit 8 of 0x00 is 1 exactly when a non-mirrored group 1 source is both active and enabled. Bit 9 follows the same rule for group 2. A mirrored source never sets either bit.
- R8: Bits 8 and above of a write to 0x18 or 0x24 have no effect. This includes the shortcut positions 10-20. The group 0 enable reads back with bits 8-31 equal to zero.
- R9: `irq_o` is high exactly when any bit 0-20 of the group 0 pending word is 1.
- R10: Reads from unmapped offsets return zero. Writes to the pending offsets change no enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_basic | input | 8 | Basic group level sources |
| src_a | input | 32 | Group 1 level sources |
| src_b | input | 32 | Group 2 level sources |
| wr_en | input | 1 | Write strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that set and disable writes act on exactly the written bits. They also check that the group 0 mask changes only through its own two registers, that a summary bit is backed by an enabled non-mirrored source, and that the interrupt line is never high without an enabled active source. Only the directed scenarios can show the exact bit order of the mirror positions and the cases where a mirrored source sets its mirror bit but not the summary bit. The same holds for the zero readback of unmapped offsets and for the fact that writes to shortcut positions in the group 0 registers are ignored.

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] src_basic,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_o
);
  localparam int NSA = 5;
  localparam int NSB = 6;
  localparam int SA_POS [NSA] = '{7, 9, 10, 18, 19};
  localparam int SB_POS [NSB] = '{21, 22, 23, 24, 25, 30};
  localparam int SUM_A  = NB;
  localparam int SUM_B  = NB + 1;
  localparam int MIR_LO = NB + 2;
  localparam int TOP0   = MIR_LO + NSA + NSB;

  localparam logic [AW-1:0] A_PEND0 = AW'(6'h00);
  localparam logic [AW-1:0] A_PEND1 = AW'(6'h04);
  localparam logic [AW-1:0] A_PEND2 = AW'(6'h08);
  localparam logic [AW-1:0] A_EN1   = AW'(6'h10);
  localparam logic [AW-1:0] A_EN2   = AW'(6'h14);
  localparam logic [AW-1:0] A_EN0   = AW'(6'h18);
  localparam logic [AW-1:0] A_DIS1  = AW'(6'h1C);
  localparam logic [AW-1:0] A_DIS2  = AW'(6'h20);
  localparam logic [AW-1:0] A_DIS0  = AW'(6'h24);

  function automatic logic [DW-1:0] mask_a();
    logic [DW-1:0] m = '0;
    for (int i = 0; i < NSA; i++) m[SA_POS[i]] = 1'b1;
    return m;
  endfunction
  function automatic logic [DW-1:0] mask_b();
    logic [DW-1:0] m = '0;
    for (int i = 0; i < NSB; i++) m[SB_POS[i]] = 1'b1;
    return m;
  endfunction
  localparam logic [DW-1:0] MASK_A = mask_a();
  localparam logic [DW-1:0] MASK_B = mask_b();

  logic [NB-1:0] en0;
  logic [DW-1:0] en1, en2;
  logic [NB-1:0] pend_basic;
  logic [DW-1:0] pend_a, pend_b;
  logic [NSA-1:0] mir_a;
  logic [NSB-1:0] mir_b;
  logic [TOP0-1:0] pend_top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en0 <= '0;
      en1 <= '0;
      en2 <= '0;
    end else if (wr_en) begin
      case (addr)
        A_EN0:   en0 <= en0 | wdata[NB-1:0];
        A_DIS0:  en0 <= en0 & ~wdata[NB-1:0];
        A_EN1:   en1 <= en1 | wdata;
        A_DIS1:  en1 <= en1 & ~wdata;
        A_EN2:   en2 <= en2 | wdata;
        A_DIS2:  en2 <= en2 & ~wdata;
        default: ;
      endcase
    end
  end

  assign pend_basic = src_basic & en0;
  assign pend_a     = src_a & en1;
  assign pend_b     = src_b & en2;

  for (genvar i = 0; i < NSA; i++) begin : g_mir_a
    assign mir_a[i] = pend_a[SA_POS[i]];
  end
  for (genvar i = 0; i < NSB; i++) begin : g_mir_b
    assign mir_b[i] = pend_b[SB_POS[i]];
  end

  assign pend_top = {mir_b, mir_a, |(pend_b & ~MASK_B), |(pend_a & ~MASK_A), pend_basic};
  assign irq_o    = |pend_top;

  always_comb begin
    rdata = '0;
    case (addr)
      A_PEND0:        rdata = DW'(pend_top);
      A_PEND1:        rdata = pend_a;
      A_PEND2:        rdata = pend_b;
      A_EN0:          rdata = DW'(en0);
      A_EN1:          rdata = en1;
      A_EN2:          rdata = en2;
      default:        rdata = '0;
    endcase
  end

  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_EN1) |=> ((en1 & $past(wdata)) == $past(wdata)));

  a_r2_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_DIS1) |=> ((en1 & $past(en1)) == $past(en1)));

  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIS2) |=> ((en2 & $past(wdata)) == '0));

  a_r8_en0_own_regs: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == A_EN0 || addr == A_DIS0)) |=> $stable(en0));

  a_r7_summary_source: assert property (@(posedge clk) disable iff (!rst_n)
    pend_top[SUM_A] |-> ((src_a & en1 & ~MASK_A) != '0));

  a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (((src_basic & en0) != '0) || ((src_a & en1) != '0) || ((src_b & en2) != '0)));

  a_r6_mirror_top: assert property (@(posedge clk) disable iff (!rst_n)
    pend_top[TOP0-1] |-> (src_b[30] && en2[30]));
endmodule

// File: tb/tb_banked_irq_ctrl.sv
module tb_banked_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_basic = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  banked_irq_ctrl dut (.clk(clk), .rst_n(rst_n), .src_basic(src_basic), .src_a(src_a),
    .src_b(src_b), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(6'h00, d); chk("R1 pend0", d, 0);
    rd(6'h18, d); chk("R1 en0", d, 0);
    rd(6'h10, d); chk("R1 en1", d, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
  endtask

  task automatic t_enable_disable;
    logic [31:0] d;
    wr(6'h10, 32'h0000_00F0); wr(6'h10, 32'h0000_0001);
    rd(6'h10, d); chk("R2 en1 set keep", d, 32'h0000_00F1);
    wr(6'h1C, 32'h0000_0030);
    rd(6'h10, d); chk("R3 en1 clear", d, 32'h0000_00C1);
    wr(6'h14, 32'hFFFF_0000); wr(6'h20, 32'h0F00_0000);
    rd(6'h14, d); chk("R3 en2 clear", d, 32'hF0FF_0000);
    wr(6'h1C, 32'hFFFF_FFFF); wr(6'h20, 32'hFFFF_FFFF);
  endtask

  task automatic t_basic;
    logic [31:0] d;
    wr(6'h18, 32'hFFFF_FF5A);
    rd(6'h18, d); chk("R8 en0 upper ignored", d, 32'h0000_005A);
    src_basic = 8'h0F;
    rd(6'h00, d); chk("R5 basic gated", d, 32'h0000_000A);
    chk("R9 irq basic", {31'd0, irq_o}, 1);
    wr(6'h24, 32'h0000_0002);
    rd(6'h00, d); chk("R5 after disable", d, 32'h0000_0008);
    wr(6'h24, 32'hFFFF_FFFF); src_basic = 0;
    rd(6'h00, d); chk("R9 pend0 empty", d, 0);
    chk("R9 irq low", {31'd0, irq_o}, 0);
  endtask

  task automatic t_shortcuts;
    logic [31:0] d;
    wr(6'h10, 32'hFFFF_FFFF); wr(6'h14, 32'hFFFF_FFFF);
    src_a = 32'h0000_0080;
    rd(6'h00, d); chk("R7 R6 bank1 src7 mirror no summary", d, 32'h0000_0400);
    rd(6'h04, d); chk("R4 pend1 keeps shortcut", d, 32'h0000_0080);
    src_a = 32'h000C_0600;
    rd(6'h00, d); chk("R6 bank1 mirrors 9,10,18,19", d, 32'h0000_7800);
    src_a = 32'h0000_0008;
    rd(6'h00, d); chk("R7 summary bank1", d, 32'h0000_0100);
    src_a = 0; src_b = 32'h43E0_0000;
    rd(6'h00, d); chk("R6 bank2 mirrors", d, 32'h001F_8000);
    src_b = 32'h4000_0001;
    rd(6'h00, d); chk("R7 R6 summary bank2 plus bit 30", d, 32'h0010_0200);
    chk("R9 irq bank2", {31'd0, irq_o}, 1);
    wr(6'h20, 32'h4000_0000);
    rd(6'h00, d); chk("R6 mirror follows own enable", d, 32'h0000_0200);
    rd(6'h08, d); chk("R4 pend2 gated", d, 32'h0000_0001);
    src_b = 0;
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    src_a = 32'h0000_0080;
    wr(6'h24, 32'h001F_FC00);
    rd(6'h00, d); chk("R8 bank0 disable of shortcut ignored", d, 32'h0000_0400);
    wr(6'h1C, 32'hFFFF_FFFF); wr(6'h18, 32'h001F_FC00);
    rd(6'h00, d); chk("R8 bank0 enable of shortcut ignored", d, 0);
    rd(6'h18, d); chk("R8 en0 unchanged", d, 0);
    wr(6'h00, 32'hFFFF_FFFF); wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h10, d); chk("R10 pending write no effect", d, 0);
    rd(6'h0C, d); chk("R10 unmapped 0x0C", d, 0);
    rd(6'h3C, d); chk("R10 unmapped 0x3C", d, 0);
    src_a = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable_disable();
    t_basic();
    t_shortcuts();
    t_ignored();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule